// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the internal word address for a pipelined synchronous memory that runs four-beat bursts. An external address is captured when either of two active-low address strobes opens a new access. The captured value then steps through a four-word group without further address traffic. The upper address bits stay frozen for the whole burst. Only the low field, two bits by default, follows the burst count.

A static order input selects how the low field moves. When it is high, which is the default for an unconnected pin, the order is interleaved and each beat is the start value XOR the beat count. When it is low, the order is linear and each beat is (start + count) modulo the group size. Stepping is requested with an active-low advance input. It is honoured only when neither strobe is asserted. In a write burst it also needs a byte strobe in the same cycle.

A chip-enable qualification gates the processor-side strobe but not the controller-side strobe. Reset is asynchronous and active low, and is released through a local two-stage synchroniser. The output is combinational from the registered base and count, so a change on the order input shows on the output without a clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: A rising edge with `adsc_n` low loads `addr_in` and clears the beat count. This holds whatever `adsp_n`, `ce_ok` and `adv_n` are. After that edge, `addr_out` equals the loaded address.
- R2: A rising edge with `adsp_n` low and `ce_ok` high loads `addr_in` and clears the count. With `adsp_n` low, `ce_ok` low and `adsc_n` high, nothing is loaded and `addr_out` keeps its value.
- R3: On an edge that loads through `adsp_n`, the level of `adv_n` has no effect. After that edge, `addr_out` equals the loaded address.
- R4: In a read (`in_write` low), the count steps by one on an edge where `adv_n` is low and both `adsp_n` and `adsc_n` are high.
- R5: In a write (`in_write` high), a step also needs `byte_strobe` high. With `byte_strobe` low the address holds.
- R6: With `order_il` = 1, the low two bits of `addr_out` are base[1:0] XOR count. For example, start 2 gives 2, 3, 0, 1.
- R7: With `order_il` = 0, the low two bits are (base[1:0] + count) mod 4. For example, start 1 gives 1, 2, 3, 0.
- R8: The step after the fourth beat returns to the first beat of the same group (the count wraps from 3 to 0).
- R9: Bits above the low two keep their loaded value on every edge that does not load.
- R10: An edge with both strobes high and `adv_n` high leaves `addr_out` unchanged.
- R11: After reset, `addr_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adsp_n | input | 1 | Processor-side address strobe, active low, gated by `ce_ok` |
| adsc_n | input | 1 | Controller-side address strobe, active low, not gated |
| adv_n | input | 1 | Burst advance request, active low |
| ce_ok | input | 1 | Chip enables are active; qualifies `adsp_n` |
| in_write | input | 1 | Current burst is a write |
| byte_strobe | input | 1 | At least one byte write strobe is asserted this cycle |
| order_il | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_in | input | AW (21) | External address |
| addr_out | output | AW (21) | Internal burst address |

## Verification
The hardest case to reach is a processor-strobe load that coincides with an asserted advance. From the ports alone, a design that wrongly honours `adv_n` on that edge would look like a load followed by a step in the same cycle. The stimulus therefore opens every burst through `adsp_n` with `adv_n` held low, for each start value in both orders, and expects the unmodified address on the next cycle. The same pattern is repeated with `ce_ok` low to show the strobe is blocked, and with a write burst that lacks a byte strobe to show the step is withheld.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/burst_ctl.sv
module burst_ctl (
  input  logic adsp_n,
  input  logic adsc_n,
  input  logic adv_n,
  input  logic ce_ok,
  input  logic in_write,
  input  logic byte_strobe,
  output logic ld,
  output logic step
);
  logic strobes_idle;
  logic wr_gate;

  always_comb begin
    // controller strobe is never gated; processor strobe needs the enables
    ld           = !adsc_n || (!adsp_n && ce_ok);
    strobes_idle = adsp_n && adsc_n;
    wr_gate      = !in_write || byte_strobe;
    step         = strobes_idle && !adv_n && wr_gate;
  end
endmodule

// File: rtl/burst_ctr.sv
module burst_ctr #(
  parameter int AW = 21,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base_q,
  output logic [BB-1:0] cnt_q
);
  localparam logic [BB-1:0] CNT_ONE = BB'(1);

  logic [AW-1:0] base_d;
  logic [BB-1:0] cnt_d;
  logic          upd_en;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    upd_en = ld || step;
    if (ld) begin
      base_d = addr_in;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d  = cnt_q + CNT_ONE;  // natural wrap inside the group
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int BB = 2
) (
  input  logic         order_il,
  input  logic [BB-1:0] base_lo,
  input  logic [BB-1:0] cnt,
  output logic [BB-1:0] beat_lo
);
  logic [BB-1:0] lin_lo;
  logic [BB-1:0] il_lo;
  burst_order_e  ord;

  assign lin_lo = base_lo + cnt;

  for (genvar i = 0; i < BB; i++) begin : g_il
    assign il_lo[i] = base_lo[i] ^ cnt[i];
  end

  always_comb begin
    ord     = burst_order_e'(order_il);
    beat_lo = (ord == ORD_INTERLEAVE) ? il_lo : lin_lo;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 21,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          ce_ok,
  input  logic          in_write,
  input  logic          byte_strobe,
  input  logic          order_il,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  logic          rst_q_n;
  logic          ld;
  logic          step;
  logic [AW-1:0] base_q;
  logic [BB-1:0] cnt_q;
  logic [BB-1:0] beat_lo;

  burst_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  burst_ctl u_ctl (
    .adsp_n      (adsp_n),
    .adsc_n      (adsc_n),
    .adv_n       (adv_n),
    .ce_ok       (ce_ok),
    .in_write    (in_write),
    .byte_strobe (byte_strobe),
    .ld          (ld),
    .step        (step)
  );

  burst_ctr #(.AW(AW), .BB(BB)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ld      (ld),
    .step    (step),
    .addr_in (addr_in),
    .base_q  (base_q),
    .cnt_q   (cnt_q)
  );

  burst_seq #(.BB(BB)) u_seq (
    .order_il (order_il),
    .base_lo  (base_q[BB-1:0]),
    .cnt      (cnt_q),
    .beat_lo  (beat_lo)
  );

  assign addr_out = {base_q[AW-1:BB], beat_lo};
endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int AW = 21,
  parameter int BB = 2
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          adsp_n,
  input logic          adsc_n,
  input logic          adv_n,
  input logic          ce_ok,
  input logic          in_write,
  input logic          byte_strobe,
  input logic          order_il,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out
);
  localparam logic [BB-1:0] ONE = BB'(1);

  p_load_adsc_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !adsc_n |=> addr_out == $past(addr_in));

  p_load_adsp_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!adsp_n && ce_ok) |=> addr_out == $past(addr_in));

  p_blocked_hold_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (adsc_n && !adsp_n && !ce_ok) |=>
      ($stable(addr_out) || order_il != $past(order_il)));

  p_adv_ignored_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!adsp_n && ce_ok && !adv_n) |=> addr_out == $past(addr_in));

  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (adsp_n && adsc_n && !adv_n && in_write && !byte_strobe) |=>
      ($stable(addr_out) || order_il != $past(order_il)));

  p_linear_step_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (adsp_n && adsc_n && !adv_n && !in_write && !order_il) |=>
      (order_il || addr_out[BB-1:0] == $past(addr_out[BB-1:0]) + ONE));

  p_upper_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (adsp_n && adsc_n) |=> $stable(addr_out[AW-1:BB]));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (adsp_n && adsc_n && adv_n) |=>
      ($stable(addr_out) || order_il != $past(order_il)));
endmodule

bind burst_addr_gen burst_addr_chk #(.AW(AW), .BB(BB)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .adsp_n      (adsp_n),
  .adsc_n      (adsc_n),
  .adv_n       (adv_n),
  .ce_ok       (ce_ok),
  .in_write    (in_write),
  .byte_strobe (byte_strobe),
  .order_il    (order_il),
  .addr_in     (addr_in),
  .addr_out    (addr_out)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          adsp_n, adsc_n, adv_n, ce_ok, in_write, byte_strobe, order_il;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW), .BB(2)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce_ok(ce_ok), .in_write(in_write), .byte_strobe(byte_strobe),
    .order_il(order_il), .addr_in(addr_in), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] model_out(input logic md);
    logic [1:0] lo;
    lo = md ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one clock cycle of stimulus, expectation pushed to the scoreboard
  task automatic cyc(input logic p_n, input logic c_n, input logic v_n, input logic ce,
                     input logic wr, input logic bs, input logic md,
                     input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    adsp_n = p_n; adsc_n = c_n; adv_n = v_n; ce_ok = ce;
    in_write = wr; byte_strobe = bs; order_il = md; addr_in = a;
    if (!c_n || (!p_n && ce)) begin
      m_base = a;
      m_cnt  = 2'd0;
    end else if (p_n && c_n && !v_n && (!wr || bs)) begin
      m_cnt = m_cnt + 2'd1;
    end
    exp_q.push_back(model_out(md));
    tag_q.push_back(tag);
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(addr_out, e, t);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] up;
    rst_n = 1'b0; adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; ce_ok = 1'b0;
    in_write = 1'b0; byte_strobe = 1'b0; order_il = 1'b1; addr_in = '0;
    m_base = '0; m_cnt = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check(addr_out, '0, "R11 reset value");

    // every start value in both orders, opened by ADSP with ADV held low
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        up = {19'h2A5C3 ^ 19'(s * 77 + md), 2'(s)};
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'(md), up, "R3 adv ignored on ADSP load");
        for (int b = 1; b < 4; b++)
          cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'(md), '1,
              md ? "R6 interleaved beat" : "R7 linear beat");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'(md), '0, "R8 wrap to first beat");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'(md), '1, "R10 idle hold");
      end
    end

    // controller strobe loads even with enables off and ADV low
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 21'h0F00D, "R1 ADSC load");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 21'h0, "R4 read advance");
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 21'h12342, "R1 ADSC with ADSP");
    // processor strobe blocked by enables: hold
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 21'h1FFFF, "R2 blocked ADSP holds");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 21'h0AAA1, "R2 ADSP load");
    // write burst: no step without a byte strobe
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 21'h0, "R5 write without strobe holds");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 21'h0, "R5 write with strobe steps");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 21'h1FFFF, "R9 upper bits kept");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 21'h1FFFF, "R10 hold in write");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 21'h0, "R8 wrap in write");

    repeat (4) @(posedge clk);
    #3;
    if (exp_q.size() != 0) begin
      n_chk++;
      n_err++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule